// File: doc/BRIEF.md
# Priority-Level Stream Request Arbiter

This block decides which of eight data-movement streams may use a shared transfer engine next. Each stream builds its request from one of eight peripheral request lines, chosen by a 3-bit selector that software sets. A stream can also be started by a software trigger with no peripheral involved, as it would be for a memory-to-memory copy. A stream is considered only while its enable bit is set.

Each stream has a 2-bit priority level. Whenever the arbiter is idle, it picks the pending stream with the highest level. If several pending streams share that level, the one with the lowest index wins. The winner receives a one-hot grant and its index. The grant stays in place until that stream pulses its transaction-done line. The grant then drops for one cycle, and a new winner is picked on the clock after that. Selector and priority inputs matter only while the arbiter is idle, so software may rewrite them during a grant without disturbing it.

Top module: `stream_req_arbiter`

## Requirements
- R1: After reset, grantVec is all zero, grantValid is 0 and grantIdx is 0.
- R2: Stream s takes its hardware request from periphReq[c], where c is the 3-bit selector in chanSel bits [3s+2:3s]. Any c from 0 to 7 can be selected, and the other peripheral lines are ignored for that stream.
- R3: A high swTrig[s] makes stream s pending even when no peripheral line is high.
- R4: A stream whose streamEn bit is 0 is never granted, whatever its request or trigger.
- R5: The priority of stream s is prioLevel bits [2s+1:2s], encoded 2'b11 very high, 2'b10 high, 2'b01 medium, 2'b00 low. The granted stream has the highest level among the pending enabled streams.
- R6: Among pending streams that share the highest level, the one with the lowest index is granted.
- R7: grantVec is one-hot or all zero. grantValid equals the OR of grantVec. While grantValid is 1, grantIdx is the position of the set bit.
- R8: When the arbiter is idle and some stream is pending at a clock edge, the grant for the winner is visible right after that edge.
- R9: Once given, a grant holds unchanged until xferDone of the granted stream is sampled high. xferDone pulses from other streams have no effect.
- R10: The clock edge that samples xferDone of the granted stream clears the grant. The next edge grants the winner among the streams pending at that moment.
- R11: Changes to chanSel, prioLevel or peripheral requests while a grant is held do not change the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| periphReq | input | 8 | Peripheral request lines |
| swTrig | input | 8 | Per-stream software trigger |
| streamEn | input | 8 | Per-stream enable |
| chanSel | input | 24 | Per-stream 3-bit request selector, stream s in bits [3s+2:3s] |
| prioLevel | input | 16 | Per-stream 2-bit priority, stream s in bits [2s+1:2s] |
| xferDone | input | 8 | Per-stream transaction-done pulse |
| grantVec | output | 8 | One-hot grant |
| grantIdx | output | 3 | Index of the granted stream |
| grantValid | output | 1 | A grant is held |

## Verification
The hardest case to reach from the ports is a tie at the top level mixed with lower-level and disabled contenders, whose requests come through different selector settings. Such a case exercises R5, R6, R2 and R4 together. The bench reaches it with a long pseudo-random sweep of enable, level, selector, request and trigger patterns, computing each expected winner arithmetically. It also runs a complete sweep of every stream against every selector value. During each held grant, the bench scrambles the levels and selectors and pulses done on every other stream, so the hold and no-effect rules are observed at the grant outputs.

// File: rtl/stream_arb_pkg.sv
package stream_arb_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadGrant;
    logic clearGrant;
  } arbStrobe_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } arbState_t;

endpackage

// File: rtl/stream_arb_ctrl.sv
module stream_arb_ctrl
  import stream_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyPending,
  input  logic       doneHit,
  input  logic       grantValid,
  output arbStrobe_t strobe
);

  arbState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe = '0;
    unique case (state)
      ST_IDLE: begin
        if (anyPending) begin
          strobe.loadGrant = 1'b1;
          stateNext = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (doneHit) begin
          strobe.clearGrant = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // Idle with a pending stream must produce a grant after the edge
  assert_grant_latency_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && anyPending) |=> grantValid);

  // Busy state and a visible grant go together
  assert_busy_has_grant_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY) |-> grantValid);

endmodule

// File: rtl/stream_arb_datapath.sv
module stream_arb_datapath
  import stream_arb_pkg::*;
#(
  parameter int NUM_STREAMS = 8,
  parameter int NUM_PERIPH  = 8,
  parameter int LEVEL_W     = 2,
  localparam int SEL_W      = $clog2(NUM_PERIPH),
  localparam int IDX_W      = $clog2(NUM_STREAMS),
  localparam int NUM_LEVELS = 1 << LEVEL_W
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_PERIPH-1:0]          periphReq,
  input  logic [NUM_STREAMS-1:0]         swTrig,
  input  logic [NUM_STREAMS-1:0]         streamEn,
  input  logic [NUM_STREAMS*SEL_W-1:0]   chanSel,
  input  logic [NUM_STREAMS*LEVEL_W-1:0] prioLevel,
  input  logic [NUM_STREAMS-1:0]         xferDone,
  input  arbStrobe_t                     strobe,
  output logic                           anyPending,
  output logic                           doneHit,
  output logic [NUM_STREAMS-1:0]         grantVec,
  output logic [IDX_W-1:0]               grantIdx,
  output logic                           grantValid
);

  logic [NUM_STREAMS-1:0] reqRaw;
  logic [NUM_STREAMS-1:0] pending;
  logic [NUM_LEVELS-1:0][NUM_STREAMS-1:0] lvlHit;
  logic [NUM_STREAMS-1:0] winMask;
  logic [NUM_STREAMS-1:0] winOneHot;
  logic [IDX_W-1:0]       winIdx;

  // Per-stream request selection
  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_reqSel
    logic [SEL_W-1:0] selField;
    assign selField   = chanSel[s*SEL_W +: SEL_W];
    assign reqRaw[s]  = periphReq[selField];
    assign pending[s] = streamEn[s] & (reqRaw[s] | swTrig[s]);
  end

  // Pending streams grouped by priority level
  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_level
    localparam logic [LEVEL_W-1:0] LVL = l;
    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_strm
      assign lvlHit[l][s] = pending[s] & (prioLevel[s*LEVEL_W +: LEVEL_W] == LVL);
    end
  end

  // Highest non-empty level
  always_comb begin
    logic found;
    found   = 1'b0;
    winMask = '0;
    for (int l = NUM_LEVELS - 1; l >= 0; l--) begin
      if (!found && (|lvlHit[l])) begin
        winMask = lvlHit[l];
        found   = 1'b1;
      end
    end
  end

  // Lowest index inside the winning level
  assign winOneHot = winMask & (~winMask + 1'b1);

  always_comb begin
    winIdx = '0;
    for (int s = NUM_STREAMS - 1; s >= 0; s--) begin
      if (winOneHot[s]) winIdx = IDX_W'(s);
    end
  end

  // Grant register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantVec <= '0;
      grantIdx <= '0;
    end else if (strobe.loadGrant) begin
      grantVec <= winOneHot;
      grantIdx <= winIdx;
    end else if (strobe.clearGrant) begin
      grantVec <= '0;
      grantIdx <= '0;
    end
  end

  assign grantValid = |grantVec;
  assign anyPending = |pending;
  assign doneHit    = |(xferDone & grantVec);

  assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec));

  assert_idx_matches_R7: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> grantVec[grantIdx]);

  assert_grant_enabled_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadGrant) |=> ((grantVec & $past(streamEn)) == grantVec));

  assert_grant_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !doneHit) |=> $stable(grantVec));

  assert_clear_after_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    doneHit |=> !grantValid);

endmodule

// File: rtl/stream_req_arbiter.sv
module stream_req_arbiter
  import stream_arb_pkg::*;
#(
  parameter int NUM_STREAMS = 8,
  parameter int NUM_PERIPH  = 8,
  parameter int LEVEL_W     = 2,
  localparam int SEL_W      = $clog2(NUM_PERIPH),
  localparam int IDX_W      = $clog2(NUM_STREAMS)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_PERIPH-1:0]          periphReq,
  input  logic [NUM_STREAMS-1:0]         swTrig,
  input  logic [NUM_STREAMS-1:0]         streamEn,
  input  logic [NUM_STREAMS*SEL_W-1:0]   chanSel,
  input  logic [NUM_STREAMS*LEVEL_W-1:0] prioLevel,
  input  logic [NUM_STREAMS-1:0]         xferDone,
  output logic [NUM_STREAMS-1:0]         grantVec,
  output logic [IDX_W-1:0]               grantIdx,
  output logic                           grantValid
);

  arbStrobe_t strobe;
  logic       anyPending;
  logic       doneHit;

  stream_arb_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .anyPending(anyPending),
    .doneHit   (doneHit),
    .grantValid(grantValid),
    .strobe    (strobe)
  );

  stream_arb_datapath #(
    .NUM_STREAMS(NUM_STREAMS),
    .NUM_PERIPH (NUM_PERIPH),
    .LEVEL_W    (LEVEL_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .periphReq (periphReq),
    .swTrig    (swTrig),
    .streamEn  (streamEn),
    .chanSel   (chanSel),
    .prioLevel (prioLevel),
    .xferDone  (xferDone),
    .strobe    (strobe),
    .anyPending(anyPending),
    .doneHit   (doneHit),
    .grantVec  (grantVec),
    .grantIdx  (grantIdx),
    .grantValid(grantValid)
  );

endmodule

// File: tb/test_stream_req_arbiter.sv
module test_stream_req_arbiter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  periphReq = '0;
  logic [7:0]  swTrig = '0;
  logic [7:0]  streamEn = '0;
  logic [23:0] chanSel = '0;
  logic [15:0] prioLevel = '0;
  logic [7:0]  xferDone = '0;
  logic [7:0]  grantVec;
  logic [2:0]  grantIdx;
  logic        grantValid;

  int checks = 0;
  int errors = 0;
  logic [31:0] rngState = 32'h1234_5678;

  always #5 clk = ~clk;

  stream_req_arbiter i_stream_req_arbiter (
    .clk(clk), .rstN(rstN), .periphReq(periphReq), .swTrig(swTrig),
    .streamEn(streamEn), .chanSel(chanSel), .prioLevel(prioLevel),
    .xferDone(xferDone), .grantVec(grantVec), .grantIdx(grantIdx),
    .grantValid(grantValid)
  );

  function automatic logic [31:0] nextRand(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // Expected winner from the requirements; -1 when nothing is pending
  function automatic int expWinner(input logic [7:0] en, input logic [7:0] trig,
                                   input logic [7:0] preq, input logic [23:0] sel,
                                   input logic [15:0] pri);
    for (int lvl = 3; lvl >= 0; lvl--) begin
      for (int s = 0; s < 8; s++) begin
        int c;
        int p;
        c = int'(sel[s*3 +: 3]);
        p = int'(pri[s*2 +: 2]);
        if (en[s] && (trig[s] || preq[c]) && p == lvl) return s;
      end
    end
    return -1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runCase(input string req, input logic [7:0] en, input logic [7:0] trig,
                         input logic [7:0] preq, input logic [23:0] sel,
                         input logic [15:0] pri);
    int w;
    logic [7:0] expVec;
    w = expWinner(en, trig, preq, sel, pri);
    expVec = (w < 0) ? 8'h00 : (8'h01 << w);
    @(negedge clk);
    streamEn = en; swTrig = trig; periphReq = preq; chanSel = sel; prioLevel = pri;
    @(negedge clk);
    chk({req, " R8 grantVec"}, 32'(grantVec), 32'(expVec));
    chk({req, " R7 grantValid"}, 32'(grantValid), 32'(w >= 0));
    if (w >= 0) begin
      chk({req, " R7 grantIdx"}, 32'(grantIdx), 32'(w));
      // scramble idle-only inputs and pulse done on other streams
      prioLevel = ~pri; chanSel = ~sel; periphReq = ~preq; xferDone = ~expVec;
      @(negedge clk);
      chk("R9 R11 grant held", 32'(grantVec), 32'(expVec));
      xferDone = expVec; streamEn = '0; swTrig = '0; periphReq = '0;
      @(negedge clk);
      chk("R10 grant cleared", 32'(grantVec), 32'h0);
      xferDone = '0;
    end else begin
      streamEn = '0; swTrig = '0; periphReq = '0;
    end
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 grantVec at reset", 32'(grantVec), 32'h0);
    chk("R1 grantValid at reset", 32'(grantValid), 32'h0);
    chk("R1 grantIdx at reset", 32'(grantIdx), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", 32'(grantVec), 32'h0);

    // R2 every stream against every selector value
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 8; c++) begin
        logic [23:0] sel;
        sel = 24'h0;
        sel[s*3 +: 3] = 3'(c);
        runCase("R2 selected line", 8'h01 << s, 8'h00, 8'h01 << c, sel, 16'h0);
        runCase("R2 other lines ignored", 8'h01 << s, 8'h00, ~(8'h01 << c), sel, 16'h0);
      end
    end

    // R3 software trigger alone
    for (int s = 0; s < 8; s++)
      runCase("R3 sw trigger", 8'hFF, 8'h01 << s, 8'h00, 24'h0, 16'h0);

    // R4 disabled streams
    runCase("R4 all disabled", 8'h00, 8'hFF, 8'hFF, 24'h0, 16'hFFFF);
    runCase("R4 top disabled", 8'hFE, 8'hFF, 8'h00, 24'h0, 16'h0003);

    // R5 encoding and R6 tie-break
    runCase("R5 very high wins", 8'hFF, 8'hFF, 8'h00, 24'h0, 16'hC000);
    runCase("R5 high over medium", 8'hFF, 8'hFF, 8'h00, 24'h0, 16'h0609);
    runCase("R6 full tie", 8'hFF, 8'hFF, 8'h00, 24'h0, 16'h5555);
    runCase("R6 tie at top", 8'hFF, 8'hFF, 8'h00, 24'h0, 16'hF0F0);

    // R10 re-arbitration on the edge after the cleared grant
    @(negedge clk);
    streamEn = 8'hFF; swTrig = 8'hFF; prioLevel = 16'h0; chanSel = '0;
    @(negedge clk);
    chk("R10 first winner", 32'(grantVec), 32'h01);
    xferDone = 8'h01; streamEn = 8'hFE;
    @(negedge clk);
    chk("R10 gap cycle", 32'(grantVec), 32'h00);
    xferDone = 8'h00;
    @(negedge clk);
    chk("R10 next winner", 32'(grantVec), 32'h02);
    xferDone = 8'h02; streamEn = 8'h00; swTrig = 8'h00;
    @(negedge clk);
    xferDone = 8'h00;

    // R5 R6 R2 R4 pseudo-random sweep
    for (int i = 0; i < 600; i++) begin
      logic [7:0] en;
      logic [7:0] trig;
      logic [7:0] preq;
      logic [23:0] sel;
      logic [15:0] pri;
      rngState = nextRand(rngState); en = rngState[7:0] | rngState[15:8];
      trig = rngState[23:16] & rngState[31:24];
      rngState = nextRand(rngState); preq = rngState[7:0]; sel = rngState[31:8];
      rngState = nextRand(rngState); pri = rngState[15:0];
      runCase("R5 R6 sweep", en, trig, preq, sel, pri);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end

endmodule